// File: doc/BRIEF.md
# Debug-Aware Machine Trap Controller

This block sequences control transfers for a small 32-bit RISC-V core running in machine mode only. It owns the interrupt-enable bits of the machine status register, the machine exception PC and cause registers, and the debug PC. The pipeline presents one event per cycle: a synchronous exception, a pending interrupt, a halt request from the debug module, or a return instruction (`mret` or `dret`). The block then decides which registers change and where instruction fetch goes next.

Debug mode is kept apart from machine traps. Entering debug mode saves only the debug PC and leaves the interrupt enables untouched, so nothing needs to be restored on the way out. An exception raised while the core runs debug-module code alters no architectural register. It only sends fetch to a fixed exception address inside the debug module, which ends program-buffer execution. This is why an unsupported instruction placed in the program buffer by a debugger does not leave the interrupt enable cleared behind the user's back.

A simple CSR port lets the pipeline read and write the four registers. Redirects are registered and appear one cycle after the event.

Top module: `dbg_trap_ctrl`

## Requirements
- R1: After reset, MIE, MPIE, mepc, mcause and dpc are 0, debug mode is off and no redirect is signalled.
- R2: The status register is at CSR address 0x300. It reads MIE at bit 3, MPIE at bit 7 and constant 1s at bits 12:11, with all other bits 0. mepc is at 0x341, mcause at 0x342 and dpc at 0x7B1. Writes through the CSR port update these registers on the next edge. A CSR write is dropped in any cycle in which an event (R3 to R8) is accepted.
- R3: An exception outside debug mode sets mepc to `pc_i`, sets mcause to the 5-bit exception code with bit 31 clear, copies MIE into MPIE, clears MIE and redirects to `MTVEC_ADDR`.
- R4: An interrupt is taken only when `irq_i` is high, MIE is 1, debug mode is off and there is neither an exception nor a halt request in that cycle. It sets mepc to `pc_i`, sets mcause to the interrupt id with bit 31 set, applies the same MIE/MPIE update as R3 and redirects to `MTVEC_ADDR`.
- R5: A halt request outside debug mode sets dpc to `pc_i`, sets debug mode and redirects to `DBG_HALT_ADDR`. MIE, MPIE, mepc and mcause are unchanged.
- R6: An exception in debug mode leaves MIE, MPIE, mepc, mcause and dpc unchanged, keeps debug mode on and redirects to `DBG_EXC_ADDR`.
- R7: `dret` in debug mode, with no exception in the same cycle, clears debug mode, leaves MIE and MPIE unchanged and redirects to dpc. Outside debug mode, `dret` is ignored.
- R8: `mret` outside debug mode sets MIE to the old MPIE, sets MPIE to 1 and redirects to mepc.
- R9: In debug mode, interrupts, halt requests and `mret` have no effect on any register or on the redirect.
- R10: `redirect_o` is a one-cycle pulse one cycle after an accepted event. Outside debug mode, events are accepted in this priority order: halt request, then exception, then interrupt, then `mret`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | PC of the instruction at the decision point |
| exc_i | input | 1 | Exception raised by that instruction |
| exc_code_i | input | 5 | Exception code |
| irq_i | input | 1 | Interrupt pending |
| irq_id_i | input | 5 | Interrupt id |
| halt_req_i | input | 1 | Halt request from the debug module |
| mret_i | input | 1 | `mret` retiring |
| dret_i | input | 1 | `dret` retiring |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target, valid with `redirect_o` |
| debug_mode_o | output | 1 | Core is in debug mode |

## Verification
The bench targets an exception inside debug mode. A design that treated it as an ordinary trap would clear MIE, overwrite mepc and mcause and jump to the trap vector. The bench also checks that entry to and exit from debug mode leave MIE set, so a design that saved or cleared the enable on halt would show MIE at 0 after `dret`. Simultaneous events test the priority order: halt over exception, exception over interrupt, and any event over a CSR write. Interrupts arriving while MIE is 0 and `mret`, halt or interrupts in debug mode must produce no redirect at all.

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl #(
  parameter logic [31:0] MTVEC_ADDR    = 32'h0000_0100,
  parameter logic [31:0] DBG_HALT_ADDR = 32'h1A11_0800,
  parameter logic [31:0] DBG_EXC_ADDR  = 32'h1A11_0808,
  parameter int          CODE_W        = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       pc_i,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] irq_id_i,
  input  logic              halt_req_i,
  input  logic              mret_i,
  input  logic              dret_i,
  input  logic              csr_we_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  output logic              redirect_o,
  output logic [31:0]       redirect_pc_o,
  output logic              debug_mode_o
);
  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_DPC    = 12'h7B1;
  localparam int          PAD_W    = 31 - CODE_W;

  logic        mie_q, mpie_q, dbg_q, redir_q;
  logic [31:0] mepc_q, mcause_q, dpc_q, rpc_q;

  wire take_halt = !dbg_q && halt_req_i;
  wire take_exc  = exc_i && !take_halt;
  wire take_irq  = !dbg_q && !halt_req_i && !exc_i && irq_i && mie_q;
  wire take_mret = !dbg_q && mret_i && !halt_req_i && !exc_i && !take_irq;
  wire take_dret = dbg_q && dret_i && !exc_i;
  wire trap      = (take_exc && !dbg_q) || take_irq;
  wire any_evt   = take_halt || take_exc || take_irq || take_mret || take_dret;

  logic [31:0] target;
  always_comb begin
    if (take_halt)              target = DBG_HALT_ADDR;
    else if (take_exc && dbg_q) target = DBG_EXC_ADDR;
    else if (trap)              target = MTVEC_ADDR;
    else if (take_mret)         target = mepc_q;
    else                        target = dpc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      dbg_q    <= 1'b0;
      redir_q  <= 1'b0;
      mepc_q   <= '0;
      mcause_q <= '0;
      dpc_q    <= '0;
      rpc_q    <= '0;
    end else begin
      redir_q <= any_evt;
      if (any_evt) rpc_q <= target;
      if (trap) begin
        mepc_q   <= pc_i;
        mcause_q <= take_exc ? {1'b0, {PAD_W{1'b0}}, exc_code_i}
                             : {1'b1, {PAD_W{1'b0}}, irq_id_i};
        mpie_q   <= mie_q;
        mie_q    <= 1'b0;
      end else if (take_mret) begin
        mie_q  <= mpie_q;
        mpie_q <= 1'b1;
      end else if (take_halt) begin
        dpc_q <= pc_i;
        dbg_q <= 1'b1;
      end else if (take_dret) begin
        dbg_q <= 1'b0;
      end else if (csr_we_i && !any_evt) begin
        case (csr_addr_i)
          A_STATUS: begin
            mie_q  <= csr_wdata_i[3];
            mpie_q <= csr_wdata_i[7];
          end
          A_EPC:   mepc_q   <= csr_wdata_i;
          A_CAUSE: mcause_q <= csr_wdata_i;
          A_DPC:   dpc_q    <= csr_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (csr_addr_i)
      A_STATUS: csr_rdata_o = {19'b0, 2'b11, 3'b0, mpie_q, 3'b0, mie_q, 3'b0};
      A_EPC:    csr_rdata_o = mepc_q;
      A_CAUSE:  csr_rdata_o = mcause_q;
      A_DPC:    csr_rdata_o = dpc_q;
      default:  csr_rdata_o = '0;
    endcase
  end

  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;
  assign debug_mode_o  = dbg_q;

  assert_halt_keeps_mie_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_q && halt_req_i) |=> dbg_q && (mie_q == $past(mie_q)) && (mpie_q == $past(mpie_q)));

  assert_trap_clears_mie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_q && !halt_req_i && exc_i) |=> !mie_q && (mpie_q == $past(mie_q)) && redirect_o);

  assert_dbg_exc_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_q && exc_i) |=> $stable(mepc_q) && $stable(mcause_q) && $stable(dpc_q)
                         && $stable(mie_q) && $stable(mpie_q) && dbg_q);

  assert_dbg_exc_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_q && exc_i) |=> redirect_o && (redirect_pc_o == DBG_EXC_ADDR));

  assert_dret_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_q && dret_i && !exc_i) |=> !dbg_q && (redirect_pc_o == $past(dpc_q))
                                    && (mie_q == $past(mie_q)));

  assert_no_irq_when_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mie_q && irq_i && !exc_i && !halt_req_i && !mret_i && !dret_i) |=> !redirect_o);
endmodule

// File: tb/dbg_trap_ctrl_test.sv
`timescale 1ns/1ps
module dbg_trap_ctrl_test;
  localparam logic [31:0] TV  = 32'h0000_0100;
  localparam logic [31:0] DH  = 32'h1A11_0800;
  localparam logic [31:0] DE  = 32'h1A11_0808;

  logic clk = 0, rst_n = 0;
  logic [31:0] pc = 0, wdata = 0;
  logic exc = 0, irq = 0, halt = 0, mret = 0, dret = 0, we = 0;
  logic [4:0] code = 0, id = 0;
  logic [11:0] addr = 12'h300;
  logic [31:0] rdata, rpc;
  logic redir, dbgm;

  always #2 clk = ~clk;

  dbg_trap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .exc_i(exc), .exc_code_i(code),
    .irq_i(irq), .irq_id_i(id), .halt_req_i(halt), .mret_i(mret), .dret_i(dret),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .redirect_o(redir), .redirect_pc_o(rpc), .debug_mode_o(dbgm));

  int errors = 0, checks = 0;
  string req = "R1";

  bit m_mie, m_mpie, m_dbg, m_red;
  logic [31:0] m_epc, m_cause, m_dpc, m_rpc;

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h300: return {19'b0, 2'b11, 3'b0, m_mpie, 3'b0, m_mie, 3'b0};
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h7B1: return m_dpc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit ev;
    if (!rst_n) begin
      m_mie = 0; m_mpie = 0; m_dbg = 0; m_red = 0;
      m_epc = 0; m_cause = 0; m_dpc = 0;
      return;
    end
    ev = 1;
    if (!m_dbg && halt) begin
      m_dpc = pc; m_dbg = 1; m_rpc = DH;
    end else if (exc && m_dbg) begin
      m_rpc = DE;
    end else if (exc) begin
      m_epc = pc; m_cause = {27'b0, code}; m_mpie = m_mie; m_mie = 0; m_rpc = TV;
    end else if (!m_dbg && irq && m_mie) begin
      m_epc = pc; m_cause = {1'b1, 26'b0, id}; m_mpie = m_mie; m_mie = 0; m_rpc = TV;
    end else if (!m_dbg && mret) begin
      m_mie = m_mpie; m_mpie = 1; m_rpc = m_epc;
    end else if (m_dbg && dret) begin
      m_dbg = 0; m_rpc = m_dpc;
    end else begin
      ev = 0;
      if (we) begin
        if (addr == 12'h300) begin m_mie = wdata[3]; m_mpie = wdata[7]; end
        else if (addr == 12'h341) m_epc = wdata;
        else if (addr == 12'h342) m_cause = wdata;
        else if (addr == 12'h7B1) m_dpc = wdata;
      end
    end
    m_red = ev;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("debug_mode", {31'b0, dbgm}, {31'b0, m_dbg});
    chk("redirect", {31'b0, redir}, {31'b0, m_red});
    if (m_red) chk("redirect_pc", rpc, m_rpc);
    chk("csr_rdata", rdata, m_read(addr));
    exc = 0; irq = 0; halt = 0; mret = 0; dret = 0; we = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1; step();
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    req = "R1";
    repeat (3) step();
    rst_n = 1;
    step();
    chk("status_reset", rdata, 32'h0000_1800);

    req = "R2";
    wr(12'h300, 32'h0000_0008);
    chk("status_mie", rdata, 32'h0000_1808);
    wr(12'h341, 32'h0000_2000); addr = 12'h341; step();
    wr(12'h7B1, 32'h0000_3000); addr = 12'h7B1; step();
    wr(12'h342, 32'h0000_0007); addr = 12'h342; step();
    addr = 12'h300; step();

    req = "R4";
    irq = 1; id = 5'd11; pc = 32'h40; wr(12'h300, 32'h0); step();
    irq = 1; id = 5'd11; pc = 32'h44; step();
    wr(12'h300, 32'h0000_0008);
    irq = 1; id = 5'd11; pc = 32'h48; step();
    addr = 12'h342; step();

    req = "R8";
    addr = 12'h300; mret = 1; step();
    chk("mret_status", rdata, 32'h0000_1888);

    req = "R3";
    exc = 1; code = 5'd2; pc = 32'h80; addr = 12'h341; step();
    addr = 12'h300; step();
    mret = 1; step();

    req = "R10";
    exc = 1; code = 5'd3; irq = 1; pc = 32'h90; addr = 12'h342; step();
    mret = 1; step();
    exc = 1; code = 5'd2; pc = 32'h94; addr = 12'h341; wdata = 32'hDEAD; we = 1; step();
    mret = 1; addr = 12'h300; step();

    req = "R5";
    halt = 1; exc = 1; pc = 32'h100; addr = 12'h7B1; step();
    addr = 12'h300; step();
    chk("halt_keeps_mie", rdata[3], 1'b1);

    req = "R6";
    exc = 1; code = 5'd2; pc = 32'h1A11_0360; step();
    addr = 12'h341; exc = 1; code = 5'd2; step();
    addr = 12'h342; step();

    req = "R9";
    irq = 1; id = 5'd7; step();
    mret = 1; step();
    halt = 1; pc = 32'h200; addr = 12'h7B1; step();

    req = "R7";
    dret = 1; exc = 1; code = 5'd2; step();
    dret = 1; addr = 12'h300; step();
    chk("dret_mie", rdata[3], 1'b1);
    dret = 1; step();

    req = "R2";
    wr(12'h7B1, 32'h0000_0500);
    halt = 1; pc = 32'h300; addr = 12'h7B1; wdata = 32'h1; we = 1; step();
    wr(12'h300, 32'h0); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule